// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a programmed run of words between one peripheral and system memory so that the processor does not copy each word itself. Software sets a start address, a word count and a control word through a small register port. That port responds only while both of its two select inputs are high. Once the channel is armed, a pending peripheral request makes the engine ask the processor for the bus. It drives no address and no strobe until the processor's grant arrives.

While it owns the bus, the engine puts the current address on the memory address lines. It pulses either the read strobe (memory to peripheral) or the write strobe (peripheral to memory) and acknowledges the peripheral in that same cycle, one word per cycle. A control bit picks how long it keeps the bus. In burst mode it keeps the bus until the whole block has moved. In cycle-stealing mode it gives the bus back after every word and asks again. When the last word has moved, the engine drops its request and raises a completion flag. That flag stays up until software writes the control word again.

Top module: `dma_engine`

## Requirements
- R1: After reset the bus request, strobes, acknowledge and completion flag are low and every register reads back as zero.
- R2: Registers are written or read only while both `sel_data` and `sel_reg` are high. `reg_idx` picks the register: 0 holds the address, 1 the word count, and 2 the control word (bit 0 arms the channel, bit 1 picks burst mode when 1, bit 2 picks peripheral-to-memory when 1). Index 3 is a read-only status word (bit 0 done, bit 1 busy). A read with either select low returns zero.
- R3: `bus_req` rises one cycle after the channel is armed with a nonzero count and `dev_req` is high. It stays low if the channel is not armed or no request is pending.
- R4: Until `bus_grant` has been seen, the engine drives no memory address, no strobe and no acknowledge.
- R5: Each word moved produces one strobe together with `dev_ack`. The strobe is `mem_wr` in peripheral-to-memory mode and `mem_rd` otherwise. Data passes straight through (`dev_rdata` to `mem_wdata`, `mem_rdata` to `dev_wdata`).
- R6: In burst mode `bus_req` stays high without a break from the first request until the block is done, and one word moves in every granted cycle.
- R7: In cycle-stealing mode `bus_req` goes low for at least one cycle after every word.
- R8: Each word moved raises the address register by one and lowers the count by one.
- R9: When the count reaches zero, `bus_req` drops and `irq` rises. `irq` stays high until the control word is written.
- R10: Register writes that arrive while a transfer is in progress (request pending or bus owned) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_data | input | 1 | First register-port select |
| sel_reg | input | 1 | Second register-port select |
| reg_idx | input | 2 | Register index |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Acknowledge to the peripheral, one per word |
| dev_rdata | input | DW | Word supplied by the peripheral |
| dev_wdata | output | DW | Word delivered to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | DW | Memory address, zero when the bus is not owned |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | Block-complete flag |

## Verification
The move of the final word and the end of the block fall in the same cycle. That cycle's strobe is the one that brings the count to zero, so the bus release and the completion flag must follow at the very next edge, with no extra strobe and no extra request cycle. This is provoked with a one-word burst, a four-word burst and a three-word cycle-stealing run. Each is judged by counting the cycles with the request high, the number of falling edges of the request, the address and count read back afterwards, and the memory or peripheral contents.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_data,
  input  logic          sel_reg,
  input  logic [1:0]    reg_idx,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] dev_wdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          irq
);

  localparam logic [1:0] IDX_ADDR = 2'd0;
  localparam logic [1:0] IDX_CNT  = 2'd1;
  localparam logic [1:0] IDX_CTL  = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} st_t;

  st_t           st_q, st_d;
  logic [DW-1:0] addr_q, cnt_q;
  logic          en_q, burst_q, tomem_q, done_q;

  wire reg_sel = sel_data & sel_reg;
  wire busy    = (st_q != ST_IDLE);
  wire wr_ok   = reg_sel & reg_we & ~busy;
  wire launch  = en_q & (cnt_q != '0) & dev_req;
  wire own     = (st_q == ST_XFER) & bus_grant;
  wire fire    = own & dev_req;
  wire last    = (cnt_q == DW'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (launch) st_d = ST_REQ;
      ST_REQ:  if (bus_grant) st_d = ST_XFER;
      ST_XFER: begin
        if (!fire || last || !burst_q) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      burst_q <= 1'b0;
      tomem_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_ok) begin
        case (reg_idx)
          IDX_ADDR: addr_q <= reg_wdata;
          IDX_CNT:  cnt_q  <= reg_wdata;
          IDX_CTL: begin
            en_q    <= reg_wdata[0];
            burst_q <= reg_wdata[1];
            tomem_q <= reg_wdata[2];
            done_q  <= 1'b0;
          end
          default: ;
        endcase
      end else if (fire) begin
        addr_q <= addr_q + DW'(1);
        cnt_q  <= cnt_q - DW'(1);
        if (last) done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      case (reg_idx)
        IDX_ADDR: reg_rdata = addr_q;
        IDX_CNT:  reg_rdata = cnt_q;
        IDX_CTL:  reg_rdata = {{(DW-3){1'b0}}, tomem_q, burst_q, en_q};
        IDX_STAT: reg_rdata = {{(DW-2){1'b0}}, busy, done_q};
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign bus_req   = (st_q == ST_REQ) | (st_q == ST_XFER);
  assign mem_addr  = own ? addr_q : '0;
  assign mem_rd    = fire & ~tomem_q;
  assign mem_wr    = fire & tomem_q;
  assign dev_ack   = fire;
  assign dev_wdata = mem_rdata;
  assign mem_wdata = dev_rdata;
  assign irq       = done_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          dev_ack,
  input logic          irq,
  input logic          burst_q,
  input logic [DW-1:0] addr_q,
  input logic [DW-1:0] cnt_q
);

  assert_strobe_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || dev_ack) |-> (bus_grant && bus_req));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_rd ^ mem_wr));

  assert_ack_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> dev_ack);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (addr_q == $past(addr_q) + DW'(1)));

  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (cnt_q == $past(cnt_q) - DW'(1)));

  assert_steal_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !burst_q) |=> !bus_req);

  assert_req_needs_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (cnt_q != '0));

  assert_done_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(dev_ack));

endmodule

bind dma_engine dma_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_ack(dev_ack), .irq(irq),
  .burst_q(burst_q), .addr_q(addr_q), .cnt_q(cnt_q)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_data = 1'b0, sel_reg = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_idx = 2'd0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic dev_req = 1'b0, dev_ack;
  logic [DW-1:0] dev_rdata = '0, dev_wdata;
  logic bus_req, bus_grant = 1'b0;
  logic [DW-1:0] mem_addr, mem_rdata = '0, mem_wdata;
  logic mem_rd, mem_wr, irq;

  dma_engine #(.DW(DW)) i_dma_engine (
    .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .sel_reg(sel_reg),
    .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] dev_log [16];
  int n_ack = 0, n_drop = 0, req_cycles = 0, n_strobe = 0, n_rd = 0, n_wr = 0;
  logic prev_req = 1'b0;
  logic grant_on = 1'b0;
  logic done_run = 1'b0;

  // bus partner: memory, peripheral data source/sink and grant logic
  initial forever begin
    @(negedge clk);
    mem_rdata = mem[mem_addr[5:0]];
    dev_rdata = 16'hA000 + n_ack[15:0];
    #1;
    if (dev_ack && mem_rd) dev_log[n_ack[3:0]] = dev_wdata;
    if (mem_wr) mem[mem_addr[5:0]] = mem_wdata;
    if (mem_rd || mem_wr || dev_ack || mem_addr != '0) n_strobe++;
    if (mem_rd) n_rd++;
    if (mem_wr) n_wr++;
    if (dev_ack) n_ack++;
    if (prev_req && !bus_req) n_drop++;
    prev_req = bus_req;
    if (bus_req) req_cycles++;
    bus_grant = grant_on && bus_req;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    n_ack = 0; n_drop = 0; req_cycles = 0; n_strobe = 0; n_rd = 0; n_wr = 0;
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [DW-1:0] val,
                           input logic sd = 1'b1, input logic sr = 1'b1);
    @(negedge clk);
    #3;
    sel_data = sd; sel_reg = sr; reg_idx = idx; reg_wdata = val; reg_we = 1'b1;
    @(posedge clk);
    #1;
    sel_data = 1'b0; sel_reg = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] idx, output logic [DW-1:0] val,
                          input logic sd = 1'b1, input logic sr = 1'b1);
    @(negedge clk);
    #3;
    sel_data = sd; sel_reg = sr; reg_idx = idx; reg_we = 1'b0;
    #1;
    val = reg_rdata;
    sel_data = 1'b0; sel_reg = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #3;
      if (irq) break;
    end
    chk(req, {31'd0, irq}, 32'd1);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 strobes", {29'd0, mem_rd, mem_wr, dev_ack}, 0);
    for (int i = 0; i < 4; i++) begin
      reg_read(2'(i), v);
      chk("R1 register zero", {16'd0, v}, 0);
    end
  endtask

  task automatic t_select();
    logic [DW-1:0] v;
    reg_write(2'd0, 16'h1234);
    reg_read(2'd0, v);
    chk("R2 address readback", {16'd0, v}, 32'h1234);
    reg_write(2'd0, 16'h5555, 1'b1, 1'b0);
    reg_write(2'd0, 16'h6666, 1'b0, 1'b1);
    reg_read(2'd0, v);
    chk("R2 half-selected write ignored", {16'd0, v}, 32'h1234);
    reg_read(2'd0, v, 1'b0, 1'b1);
    chk("R2 unselected read is zero", {16'd0, v}, 0);
    reg_write(2'd2, 16'h0006);
    reg_read(2'd2, v);
    chk("R2 control readback", {16'd0, v}, 32'h6);
    reg_write(2'd2, 16'h0000);
  endtask

  task automatic t_disarmed();
    reg_write(2'd1, 16'd5);
    reg_write(2'd2, 16'h0000);
    dev_req = 1'b1;
    clear_stats();
    idle_cycles(5);
    chk("R3 no request while disarmed", req_cycles, 0);
    dev_req = 1'b0;
  endtask

  task automatic t_grant_withheld();
    logic [DW-1:0] v;
    grant_on = 1'b0;
    reg_write(2'd0, 16'd30);
    reg_write(2'd1, 16'd2);
    reg_write(2'd2, 16'h0007);
    clear_stats();
    idle_cycles(3);
    chk("R3 no request without dev_req", req_cycles, 0);
    @(negedge clk); #3; dev_req = 1'b1;
    @(negedge clk); #3;
    chk("R3 request one cycle after dev_req", {31'd0, bus_req}, 1);
    idle_cycles(4);
    chk("R4 nothing driven before grant", n_strobe, 0);
    reg_write(2'd1, 16'd9);
    reg_read(2'd1, v);
    chk("R10 count write ignored while busy", {16'd0, v}, 32'd2);
    grant_on = 1'b1;
    wait_irq("R9 irq after withheld grant");
    dev_req = 1'b0;
    reg_read(2'd0, v);
    chk("R8 address after two words", {16'd0, v}, 32'd32);
    chk("R10 memory word 0", {16'd0, mem[30]}, 32'hA000);
    chk("R10 memory word 1", {16'd0, mem[31]}, 32'hA001);
  endtask

  task automatic t_burst();
    logic [DW-1:0] v;
    grant_on = 1'b1;
    reg_write(2'd0, 16'd8);
    reg_write(2'd1, 16'd4);
    reg_write(2'd2, 16'h0007);
    chk("R9 control write clears irq", {31'd0, irq}, 0);
    clear_stats();
    dev_req = 1'b1;
    wait_irq("R9 irq after burst");
    dev_req = 1'b0;
    chk("R9 request dropped at completion", {31'd0, bus_req}, 0);
    idle_cycles(3);
    chk("R6 request cycles in burst", req_cycles, 5);
    chk("R6 single release in burst", n_drop, 1);
    chk("R5 write strobes only", n_wr, 4);
    chk("R5 no read strobes", n_rd, 0);
    for (int i = 0; i < 4; i++)
      chk("R5 burst data in memory", {16'd0, mem[8 + i]}, 32'hA000 + 32'(i));
    reg_read(2'd0, v);
    chk("R8 address after burst", {16'd0, v}, 32'd12);
    reg_read(2'd1, v);
    chk("R8 count after burst", {16'd0, v}, 0);
    reg_read(2'd3, v);
    chk("R2 status done not busy", {16'd0, v}, 32'h1);
  endtask

  task automatic t_steal();
    logic [DW-1:0] v;
    grant_on = 1'b1;
    for (int i = 0; i < 3; i++) mem[20 + i] = 16'h5100 + 16'(i);
    reg_write(2'd0, 16'd20);
    reg_write(2'd1, 16'd3);
    reg_write(2'd2, 16'h0001);
    clear_stats();
    dev_req = 1'b1;
    wait_irq("R9 irq after cycle stealing");
    dev_req = 1'b0;
    idle_cycles(3);
    chk("R7 release after every word", n_drop, 3);
    chk("R7 request cycles in stealing", req_cycles, 6);
    chk("R5 read strobes only", n_rd, 3);
    chk("R5 no write strobes", n_wr, 0);
    for (int i = 0; i < 3; i++)
      chk("R5 data delivered to peripheral", {16'd0, dev_log[i]}, 32'h5100 + 32'(i));
    reg_read(2'd0, v);
    chk("R8 address after stealing", {16'd0, v}, 32'd23);
  endtask

  task automatic t_single();
    grant_on = 1'b1;
    reg_write(2'd0, 16'd40);
    reg_write(2'd1, 16'd1);
    reg_write(2'd2, 16'h0007);
    clear_stats();
    dev_req = 1'b1;
    wait_irq("R9 irq after one-word burst");
    dev_req = 1'b0;
    idle_cycles(3);
    chk("R9 one-word burst request cycles", req_cycles, 2);
    chk("R9 one-word burst single ack", n_ack, 1);
    chk("R5 one-word data", {16'd0, mem[40]}, 32'hA000);
    reg_write(2'd2, 16'h0000);
    idle_cycles(1);
    chk("R9 control write clears irq", {31'd0, irq}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    t_reset();
    t_select();
    t_disarmed();
    t_grant_withheld();
    t_burst();
    t_steal();
    t_single();
    if (!done_run) begin
      done_run = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule